// File: doc/BRIEF.md
# Driver Protection and Status Controller

This block sits between the committed control word of a twelve-channel output driver and the power stages. Six channels are low-side and six are high-side, interleaved low, high, low, high. The block takes digital fault levels: supply undervoltage, per-channel overcurrent, thermal prewarning, thermal shutdown, the hardware inhibit pin and per-channel open-load comparators. From these it decides which channel enables actually reach the stages. It keeps sticky fault flags until software clears them, and it assembles the 16-bit status word that the serial interface shifts out.

The delay timers run from a slow tick. A parameterised prescaler divides the system clock down to that tick, nominally 1 kHz. Each channel has its own short-circuit state machine with the states SC_IDLE, SC_TIMING and SC_LATCHED:
- IDLE goes to TIMING when overcurrent appears.
- TIMING returns to IDLE when overcurrent drops.
- TIMING goes to LATCHED when the selected delay expires, or at once when prewarning is active.
- LATCHED returns to IDLE on a clear pulse.

The undervoltage monitor has the states UV_OK, UV_WAIT and UV_FAIL:
- OK goes to WAIT when undervoltage appears.
- WAIT returns to OK when undervoltage clears.
- WAIT goes to FAIL on expiry.
- FAIL returns to OK when undervoltage clears.

A thermal state machine has the states TH_RUN and TH_LOCK:
- RUN goes to LOCK on shutdown.
- LOCK returns to RUN only on a clear pulse while shutdown is low.

Top module: `drv_guard`

## Requirements
- R1: After reset no fault flag is set. Status bits 13 (short-circuit) and 15 (power-fail) read 0, and each channel enable follows its command bit.
- R2: Channel k of en_o (even k low-side, odd k high-side) equals ch_on_i[k] when no protection is active. Its status appears at bit k+1 of status_o.
- R3: When sw_run_i is 0 or inh_pin_i is 0, every en_o bit is 0 and status bit 14 reads 1.
- R4: A channel whose overcurrent input stays high is switched off and status bit 13 is set. This happens after SC_SHORT_TICKS ticks with dly_long_i low, or after SC_LONG_TICKS ticks with dly_long_i high. Other channels are unaffected.
- R5: If a channel's overcurrent input drops before expiry, its delay restarts from zero on the next assertion.
- R6: When tp_i is high while a channel's overcurrent input is high, that channel turns off on the next clock and bit 13 is set.
- R7: A flt_clr_i pulse clears bit 13 and re-enables channels that were latched off by short circuit.
- R8: Undervoltage held for UV_TICKS ticks turns every channel off and sets bit 15. The channels return on the first clock after uv_i falls, but bit 15 stays 1 until a flt_clr_i pulse.
- R9: Thermal shutdown turns all channels off on the next clock and forces status_o to all ones. The lock ends only on a flt_clr_i pulse given while tsd_i is low. A pulse while tsd_i is high has no effect.
- R10: When olden_n_i is 0 and a channel's command is off, its status bit shows ol_i (1 = open). Otherwise the bit shows the channel's en_o.
- R11: Status bit 0 follows tp_i directly and is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_on_i | input | 12 | Commanded channel enables, bit k = channel k |
| sw_run_i | input | 1 | Software run bit, 0 = standby |
| olden_n_i | input | 1 | Open-load detect, 0 = detect enabled |
| dly_long_i | input | 1 | Short-circuit delay select, 1 = long |
| flt_clr_i | input | 1 | One-cycle fault clear pulse from the serial interface |
| inh_pin_i | input | 1 | Hardware inhibit pin, 0 = standby |
| uv_i | input | 1 | Supply undervoltage level |
| tp_i | input | 1 | Thermal prewarning level |
| tsd_i | input | 1 | Thermal shutdown level |
| oc_i | input | 12 | Per-channel overcurrent levels |
| ol_i | input | 12 | Per-channel open-load comparator levels |
| en_o | output | 12 | Gated channel enables to the power stages |
| status_o | output | 16 | Status word: prewarn, channels, short, inhibit, power-fail |

## Verification
The bench builds the block with TICK_DIV = 4, SC_SHORT_TICKS = 2, SC_LONG_TICKS = 6 and UV_TICKS = 3. With these values the short-circuit and undervoltage windows are a few tens of clocks instead of millions. This brings both delay selections, the restart of a timer that was interrupted and the undervoltage expiry within a short run. The tick phase is not known to the bench, so each delay is checked from both sides: still on one cycle before the earliest possible expiry, and off after the latest possible one.

// File: rtl/drv_guard_pkg.sv
package drv_guard_pkg;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_TIMING,
        SC_LATCHED
    } sc_state_e;

    typedef enum logic [1:0] {
        UV_OK,
        UV_WAIT,
        UV_FAIL
    } uv_state_e;

    typedef enum logic {
        TH_RUN,
        TH_LOCK
    } th_state_e;

endpackage

// File: rtl/drv_tick.sv
module drv_tick #(
    parameter int DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/drv_sc_chan.sv
module drv_sc_chan
    import drv_guard_pkg::*;
#(
    parameter int SHORT_T = 2,
    parameter int LONG_T  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic oc_i,
    input  logic tp_i,
    input  logic long_i,
    input  logic clr_i,
    output logic latched_o
);
    localparam int MAXT = (LONG_T > SHORT_T) ? LONG_T : SHORT_T;
    localparam int CW   = $clog2(MAXT + 1);

    sc_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = long_i ? CW'(LONG_T) : CW'(SHORT_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SC_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SC_IDLE: begin
                    cnt_q <= '0;
                    if (oc_i)
                        st_q <= tp_i ? SC_LATCHED : SC_TIMING;
                end
                SC_TIMING: begin
                    if (!oc_i) begin
                        st_q  <= SC_IDLE;
                        cnt_q <= '0;
                    end else if (tp_i) begin
                        st_q <= SC_LATCHED;
                    end else if (tick_i) begin
                        if (cnt_q + 1'b1 >= limit)
                            st_q <= SC_LATCHED;
                        else
                            cnt_q <= cnt_q + 1'b1;
                    end
                end
                SC_LATCHED: begin
                    cnt_q <= '0;
                    if (clr_i)
                        st_q <= SC_IDLE;
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end

    always_comb begin
        latched_o = (st_q == SC_LATCHED);
    end
endmodule

// File: rtl/drv_uv_mon.sv
module drv_uv_mon
    import drv_guard_pkg::*;
#(
    parameter int UV_T = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic uv_i,
    input  logic clr_i,
    output logic off_o,
    output logic pf_o
);
    localparam int CW = $clog2(UV_T + 1);

    uv_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic          pf_q;
    logic          expire;

    assign expire = (st_q == UV_WAIT) && uv_i && tick_i && (cnt_q + 1'b1 >= CW'(UV_T));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= UV_OK;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                UV_OK: begin
                    cnt_q <= '0;
                    if (uv_i)
                        st_q <= UV_WAIT;
                end
                UV_WAIT: begin
                    if (!uv_i)
                        st_q <= UV_OK;
                    else if (expire)
                        st_q <= UV_FAIL;
                    else if (tick_i)
                        cnt_q <= cnt_q + 1'b1;
                end
                UV_FAIL: begin
                    cnt_q <= '0;
                    if (!uv_i)
                        st_q <= UV_OK;
                end
                default: st_q <= UV_OK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pf_q <= 1'b0;
        else if (expire)
            pf_q <= 1'b1;
        else if (clr_i)
            pf_q <= 1'b0;
    end

    always_comb begin
        off_o = (st_q == UV_FAIL);
        pf_o  = pf_q;
    end
endmodule

// File: rtl/drv_guard.sv
module drv_guard
    import drv_guard_pkg::*;
#(
    parameter int NCH            = 12,
    parameter int TICK_DIV       = 250000,
    parameter int SC_SHORT_TICKS = 2,
    parameter int SC_LONG_TICKS  = 12,
    parameter int UV_TICKS       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ch_on_i,
    input  logic             sw_run_i,
    input  logic             olden_n_i,
    input  logic             dly_long_i,
    input  logic             flt_clr_i,
    input  logic             inh_pin_i,
    input  logic             uv_i,
    input  logic             tp_i,
    input  logic             tsd_i,
    input  logic [NCH-1:0]   oc_i,
    input  logic [NCH-1:0]   ol_i,
    output logic [NCH-1:0]   en_o,
    output logic [NCH+3:0]   status_o
);
    localparam int SW = NCH + 4;

    logic           tick;
    logic [NCH-1:0] sc_lat;
    logic           uv_off;
    logic           pf_flag;
    logic           inhibit;
    logic           th_lock;
    th_state_e      th_q;
    logic [NCH-1:0] ch_view;

    drv_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            drv_sc_chan #(
                .SHORT_T (SC_SHORT_TICKS),
                .LONG_T  (SC_LONG_TICKS)
            ) u_sc (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick),
                .oc_i      (oc_i[k]),
                .tp_i      (tp_i),
                .long_i    (dly_long_i),
                .clr_i     (flt_clr_i),
                .latched_o (sc_lat[k])
            );
        end
    endgenerate

    drv_uv_mon #(.UV_T(UV_TICKS)) u_uv (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .uv_i   (uv_i),
        .clr_i  (flt_clr_i),
        .off_o  (uv_off),
        .pf_o   (pf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            th_q <= TH_RUN;
        end else begin
            unique case (th_q)
                TH_RUN:  if (tsd_i) th_q <= TH_LOCK;
                TH_LOCK: if (!tsd_i && flt_clr_i) th_q <= TH_RUN;
                default: th_q <= TH_RUN;
            endcase
        end
    end

    always_comb begin
        th_lock = (th_q == TH_LOCK);
        inhibit = !sw_run_i || !inh_pin_i;
        en_o    = ch_on_i & ~sc_lat & {NCH{!inhibit && !uv_off && !th_lock}};
        for (int k = 0; k < NCH; k++)
            ch_view[k] = (!olden_n_i && !ch_on_i[k]) ? ol_i[k] : en_o[k];
        if (th_lock)
            status_o = {SW{1'b1}};
        else
            status_o = {pf_flag, inhibit, |sc_lat, ch_view, tp_i};
    end
endmodule

// File: rtl/drv_guard_chk.sv
module drv_guard_chk #(
    parameter int NCH = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sw_run_i,
    input logic           inh_pin_i,
    input logic           flt_clr_i,
    input logic           tp_i,
    input logic           tsd_i,
    input logic [NCH-1:0] ch_on_i,
    input logic [NCH-1:0] oc_i,
    input logic [NCH-1:0] en_o,
    input logic [NCH+3:0] status_o,
    input logic           th_lock,
    input logic           pf_flag
);
    p_en_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o & ~ch_on_i) == '0);

    p_inhibit_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_run_i || !inh_pin_i) |-> (en_o == '0 && status_o[NCH+2]));

    p_pf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && !flt_clr_i) |=> pf_flag);

    p_tsd_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_i |=> (en_o == '0 && status_o == '1));

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (th_lock && (tsd_i || !flt_clr_i)) |=> th_lock);

    p_tp_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !th_lock |-> (status_o[0] == tp_i));

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_fast
            p_fast_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (oc_i[k] && tp_i && !flt_clr_i) |=> !en_o[k]);
        end
    endgenerate
endmodule

bind drv_guard drv_guard_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_run_i  (sw_run_i),
    .inh_pin_i (inh_pin_i),
    .flt_clr_i (flt_clr_i),
    .tp_i      (tp_i),
    .tsd_i     (tsd_i),
    .ch_on_i   (ch_on_i),
    .oc_i      (oc_i),
    .en_o      (en_o),
    .status_o  (status_o),
    .th_lock   (th_lock),
    .pf_flag   (pf_flag)
);

// File: tb/test_drv_guard.sv
module test_drv_guard;
    localparam int NCH  = 12;
    localparam int DIV  = 4;
    localparam int SHT  = 2;
    localparam int LNG  = 6;
    localparam int UVT  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_on = '0;
    logic           sw_run = 1'b1;
    logic           olden_n = 1'b1;
    logic           dly_long = 1'b0;
    logic           flt_clr = 1'b0;
    logic           inh_pin = 1'b1;
    logic           uv = 1'b0;
    logic           tp = 1'b0;
    logic           tsd = 1'b0;
    logic [NCH-1:0] oc = '0;
    logic [NCH-1:0] ol = '0;
    logic [NCH-1:0] en_o;
    logic [15:0]    status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string          req;
        logic [15:0]    st;
        logic [NCH-1:0] en;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    drv_guard #(
        .NCH            (NCH),
        .TICK_DIV       (DIV),
        .SC_SHORT_TICKS (SHT),
        .SC_LONG_TICKS  (LNG),
        .UV_TICKS       (UVT)
    ) i_drv_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_on_i    (ch_on),
        .sw_run_i   (sw_run),
        .olden_n_i  (olden_n),
        .dly_long_i (dly_long),
        .flt_clr_i  (flt_clr),
        .inh_pin_i  (inh_pin),
        .uv_i       (uv),
        .tp_i       (tp),
        .tsd_i      (tsd),
        .oc_i       (oc),
        .ol_i       (ol),
        .en_o       (en_o),
        .status_o   (status_o)
    );

    function automatic logic [15:0] mk_st(logic pf, logic inh, logic sc,
                                          logic [NCH-1:0] en, logic t);
        logic [NCH-1:0] v;
        for (int k = 0; k < NCH; k++)
            v[k] = (!olden_n && !ch_on[k]) ? ol[k] : en[k];
        return {pf, inh, sc, v, t};
    endfunction

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string req, logic [15:0] st, logic [NCH-1:0] en);
        exp_t it;
        it.req = req;
        it.st  = st;
        it.en  = en;
        q.push_back(it);
        wait (q.size() == 0);
        cyc(0);
    endtask

    task automatic pulse_clr();
        flt_clr = 1'b1;
        cyc(1);
        flt_clr = 1'b0;
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (en_o !== it.en || status_o !== it.st) begin
                    n_bad++;
                    $display("FAIL %s: en=%h status=%h expected en=%h status=%h",
                             it.req, en_o, status_o, it.en, it.st);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        logic [NCH-1:0] all;
        all = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        expect_now("R1", 16'h0000, '0);

        // R2 command patterns
        ch_on = 12'hA5C; cyc(1);
        expect_now("R2", mk_st(0, 0, 0, 12'hA5C, 0), 12'hA5C);
        ch_on = 12'h5A3; cyc(1);
        expect_now("R2", mk_st(0, 0, 0, 12'h5A3, 0), 12'h5A3);

        // R3 inhibit by software and by pin
        ch_on = all;
        sw_run = 1'b0; cyc(1);
        expect_now("R3", mk_st(0, 1, 0, '0, 0), '0);
        sw_run = 1'b1; inh_pin = 1'b0; cyc(1);
        expect_now("R3", mk_st(0, 1, 0, '0, 0), '0);
        inh_pin = 1'b1; cyc(1);
        expect_now("R3", mk_st(0, 0, 0, all, 0), all);

        // R4 short delay on channel 3
        dly_long = 1'b0;
        oc[3] = 1'b1; cyc(1 + DIV * (SHT - 1));
        expect_now("R4", mk_st(0, 0, 0, all, 0), all);
        cyc(DIV);
        expect_now("R4", mk_st(0, 0, 1, all & ~12'h008, 0), all & ~12'h008);
        oc[3] = 1'b0; cyc(1);
        expect_now("R4", mk_st(0, 0, 1, all & ~12'h008, 0), all & ~12'h008);
        // R7 clear re-enables
        pulse_clr();
        expect_now("R7", mk_st(0, 0, 0, all, 0), all);

        // R4 long delay on channel 8
        dly_long = 1'b1;
        oc[8] = 1'b1; cyc(1 + DIV * (LNG - 1));
        expect_now("R4", mk_st(0, 0, 0, all, 0), all);
        cyc(DIV);
        expect_now("R4", mk_st(0, 0, 1, all & ~12'h100, 0), all & ~12'h100);
        oc[8] = 1'b0; pulse_clr();
        expect_now("R7", mk_st(0, 0, 0, all, 0), all);

        // R5 restart after an interrupted overcurrent
        oc[2] = 1'b1; cyc(16);
        oc[2] = 1'b0; cyc(1);
        oc[2] = 1'b1; cyc(1 + DIV * (LNG - 1));
        expect_now("R5", mk_st(0, 0, 0, all, 0), all);
        cyc(DIV);
        expect_now("R5", mk_st(0, 0, 1, all & ~12'h004, 0), all & ~12'h004);
        oc[2] = 1'b0; pulse_clr();
        dly_long = 1'b0;

        // R6 prewarning bypasses the delay
        tp = 1'b1; oc[5] = 1'b1; cyc(1);
        expect_now("R6", mk_st(0, 0, 1, all & ~12'h020, 1), all & ~12'h020);
        oc[5] = 1'b0; tp = 1'b0; pulse_clr();
        expect_now("R7", mk_st(0, 0, 0, all, 0), all);

        // R11 prewarning bit follows input
        tp = 1'b1; cyc(1);
        expect_now("R11", mk_st(0, 0, 0, all, 1), all);
        tp = 1'b0; cyc(1);
        expect_now("R11", mk_st(0, 0, 0, all, 0), all);

        // R8 undervoltage
        uv = 1'b1; cyc(1 + DIV * (UVT - 1));
        expect_now("R8", mk_st(0, 0, 0, all, 0), all);
        cyc(DIV);
        expect_now("R8", mk_st(1, 0, 0, '0, 0), '0);
        uv = 1'b0; cyc(1);
        expect_now("R8", mk_st(1, 0, 0, all, 0), all);
        pulse_clr();
        expect_now("R8", mk_st(0, 0, 0, all, 0), all);

        // R9 thermal shutdown
        tsd = 1'b1; cyc(1);
        expect_now("R9", 16'hFFFF, '0);
        pulse_clr();
        expect_now("R9", 16'hFFFF, '0);
        tsd = 1'b0; cyc(1);
        expect_now("R9", 16'hFFFF, '0);
        pulse_clr();
        expect_now("R9", mk_st(0, 0, 0, all, 0), all);

        // R10 open-load reporting
        olden_n = 1'b0; ch_on = 12'h0F0; ol = 12'h0FF; cyc(1);
        expect_now("R10", {3'b000, 12'h0FF, 1'b0}, 12'h0F0);
        olden_n = 1'b1; cyc(1);
        expect_now("R10", {3'b000, 12'h0F0, 1'b0}, 12'h0F0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule